// File: doc/BRIEF.md
# Three-Bit Bidirectional Gray Counter

This block is a synchronous three-bit counter whose output walks the reflected Gray code, so only one output bit changes on any step. One input picks the direction: the counter moves forward through the code or backward through the same code. The code sequence wraps around at both ends.

All three state bits are held in one register bank on a single clock. A synchronous reset returns the counter to zero. A count enable gates stepping, and while it is low the value holds. Typical uses are position tracking and pointers that cross clock domains, where a single-bit change per step keeps any sampled value valid.

Top module: `gray_updn_counter`

## Requirements
- R1: With `en` high and `up` high, each rising clock edge advances `gray_q` along the forward order 000, 001, 011, 010, 110, 111, 101, 100.
- R2: With `en` high and `up` low, each rising clock edge moves `gray_q` one place backward in that same order. For example, 110 goes to 010 and 001 goes to 000.
- R3: Stepping forward from 100 gives 000.
- R4: Stepping backward from 000 gives 100.
- R5: While `rst` is high at a rising edge, `gray_q` becomes 000 at that edge, whatever `en` and `up` are.
- R6: While `en` is low and `rst` is low, `gray_q` keeps its value across the edge for either level of `up`.
- R7: Every enabled step changes exactly one bit of `gray_q`.
- R8: A new level on `up` applies at the first enabled edge after it is presented. The counter moves exactly one place in the new direction, with no repeated or skipped code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all state bits |
| rst | input | 1 | Synchronous reset, active high, overrides counting |
| en | input | 1 | Count enable, active high |
| up | input | 1 | Direction: 1 steps forward, 0 steps backward |
| gray_q | output | 3 | Registered Gray-coded count |

## Verification
The output is the state itself, so a wrong next-state shows on `gray_q` one edge after the faulty step. It appears as a skipped code, a code that repeats, or a change in two bits. A fault in the hold or reset gating shows up at the first edge where `en` or `rst` matters. The bench compares against its model on every cycle, so any such fault is caught in the same cycle it appears. Direction reversals at each end of the code exercise the two wrap paths, where an off-by-one in the conversion would most likely hide.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;
  localparam int GW = 3;
  localparam int GSTATES = 1 << GW;
  typedef logic [GW-1:0] gcode_t;

  // Gray to binary: each binary bit is the XOR of all Gray bits at or above it
  function automatic gcode_t gray_to_bin(gcode_t g);
    gcode_t b;
    b[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  function automatic gcode_t bin_to_gray(gcode_t b);
    return b ^ (b >> 1);
  endfunction

  // One place forward or backward through the code, wrapping modulo GSTATES
  function automatic gcode_t gray_step(gcode_t g, logic fwd);
    gcode_t b;
    b = gray_to_bin(g);
    b = fwd ? b + gcode_t'(1) : b - gcode_t'(1);
    return bin_to_gray(b);
  endfunction
endpackage

// File: rtl/gcnt_next.sv
module gcnt_next
  import gcnt_pkg::*;
(
  input  gcode_t cur,
  input  logic   fwd,
  output gcode_t nxt
);
  assign nxt = gray_step(cur, fwd);
endmodule

// File: rtl/gcnt_reg.sv
module gcnt_reg
  import gcnt_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  gcode_t d,
  output gcode_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/gray_updn_counter.sv
module gray_updn_counter
  import gcnt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          up,
  output logic [GW-1:0] gray_q
);
  // Named internal events for the checker
  logic   step_fire;
  gcode_t nxt_code;
  gcode_t cur_code;

  assign step_fire = en & ~rst;

  gcnt_next u_next (
    .cur (cur_code),
    .fwd (up),
    .nxt (nxt_code)
  );

  gcnt_reg u_reg (
    .clk  (clk),
    .rst  (rst),
    .load (step_fire),
    .d    (nxt_code),
    .q    (cur_code)
  );

  assign gray_q = cur_code;
endmodule

// File: rtl/gray_updn_counter_chk.sv
module gray_updn_counter_chk
  import gcnt_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          up,
  input logic [GW-1:0] gray_q,
  input logic          step_fire
);
  // Independent decode: binary bit i is the parity of the Gray bits from i upward
  function automatic logic [GW-1:0] chk_g2b(logic [GW-1:0] g);
    logic [GW-1:0] b;
    for (int i = 0; i < GW; i++) begin
      b[i] = ^(g >> i);
    end
    return b;
  endfunction

  a_r5_reset_zero: assert property (@(posedge clk) rst |=> gray_q == '0);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(gray_q));

  a_r7_one_bit: assert property (@(posedge clk) disable iff (rst)
    step_fire |=> $countones(gray_q ^ $past(gray_q)) == 1);

  a_r1_forward: assert property (@(posedge clk) disable iff (rst)
    (en && up) |=> chk_g2b(gray_q) == chk_g2b($past(gray_q)) + 3'd1);

  a_r2_backward: assert property (@(posedge clk) disable iff (rst)
    (en && !up) |=> chk_g2b(gray_q) == chk_g2b($past(gray_q)) - 3'd1);

  a_r3_wrap_fwd: assert property (@(posedge clk) disable iff (rst)
    (en && up && gray_q == 3'b100) |=> gray_q == 3'b000);

  a_r4_wrap_back: assert property (@(posedge clk) disable iff (rst)
    (en && !up && gray_q == 3'b000) |=> gray_q == 3'b100);

  // R8: the step is taken in the direction presented at that edge
  a_r8_dir_switch: assert property (@(posedge clk) disable iff (rst)
    (en && $changed(up)) |=> !$stable(gray_q));
endmodule

bind gray_updn_counter gray_updn_counter_chk u_chk (.*);

// File: tb/gray_updn_counter_bench.sv
module gray_updn_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic       up  = 1'b1;
  logic [2:0] gray_q;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  int seq[$] = '{0, 1, 3, 2, 6, 7, 5, 4};
  int idx = 0;
  int prev_val = 0;

  always #10 clk = ~clk;

  gray_updn_counter u_gray_updn_counter (
    .clk(clk), .rst(rst), .en(en), .up(up), .gray_q(gray_q)
  );

  always @(posedge clk) cycles++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive at negedge, let one edge pass, update model, compare at next negedge
  task automatic step(input bit r, input bit e, input bit u, input string tag);
    int ones;
    rst = r; en = e; up = u;
    prev_val = int'(gray_q);
    @(posedge clk);
    if (r) idx = 0;
    else if (e) idx = u ? (idx + 1) % 8 : (idx + 7) % 8;
    @(negedge clk);
    chk(int'(gray_q) == seq[idx], tag, int'(gray_q), seq[idx]);
    if (!r && e) begin
      ones = $countones(gray_q ^ prev_val[2:0]);
      chk(ones == 1, "R7 single-bit change", ones, 1);
    end
  endtask

  initial begin
    @(negedge clk);
    step(1, 0, 1, "R5 reset state");
    step(1, 1, 1, "R5 reset beats enable");
    for (int i = 0; i < 9; i++) step(0, 1, 1, "R1 forward order / R3 wrap");
    step(0, 1, 1, "R1 forward");
    for (int i = 0; i < 4; i++) step(0, 0, i[0], "R6 hold with enable low");
    for (int i = 0; i < 10; i++) step(0, 1, 0, "R2 backward order / R4 wrap");
    step(1, 0, 0, "R5 reset");
    step(0, 1, 0, "R4 backward wrap from 000");
    step(0, 1, 1, "R3 forward wrap from 100");
    for (int i = 0; i < 12; i++) step(0, 1, i[0], "R8 alternating direction");
    for (int i = 0; i < 12; i++) step(0, 1, i[1], "R8 paired direction change");
    step(0, 0, 1, "R6 hold");
    step(0, 0, 0, "R6 hold");
    step(1, 1, 0, "R5 reset beats backward step");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 5000 || done);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule